// File: doc/BRIEF.md
# Control Endpoint Stage Sequencer

This block follows a control transfer on endpoint 0 through its setup, data and status stages. A token decoder feeds it one-cycle token pulses (SETUP, IN, OUT) and a pulse when a transaction has completed. Firmware supplies receive and transmit enable bits and receive and transmit stall bits. For every token, the block registers the handshake the serial engine should return. At the end of each transaction that belongs to a control request, it raises a one-cycle general interrupt.

When a SETUP token arrives, the token decoder also presents the request direction bit (bit 7 of the request-type byte, where 1 means device-to-host) and the 16-bit requested data length. From these two values the sequencer works out whether a data stage follows and in which direction it runs. For a read, the status stage result is carried by the handshake of the host's OUT status transaction. For a write, or a read with no data, the status result is carried by the data of an IN status transaction. In both cases, the handshake choice comes from the firmware bits.

Top module: `ctl_ep_seq`

## Requirements
- R1: After reset, `stage` is 0 (idle), and `hs_valid` and `gen_irq` are both 0.
- R2: A SETUP token in any stage gives `hs_valid`=1 with `hs_code`=1 (ACK) in the next cycle, whatever the firmware bits are. It sets `stage` to 1 (setup) and latches `dir_read` from `setup_dir_in`. Handshake codes: 1 is ACK, 2 is NAK, 3 is STALL.
- R3: An IN or OUT token that arrives while `stage` is 0 (idle) or 1 (setup) is answered with code 3 (STALL), and `stage` does not change.
- R4: In the data and status stages, a handshake that is taken from firmware uses the transmit bits for IN and the receive bits for OUT. A set stall bit gives STALL. Otherwise a clear enable bit gives NAK. Otherwise the answer is ACK.
- R5: A `xact_done` pulse while `stage` is not 0 gives `gen_irq`=1 for exactly the next cycle. A `xact_done` pulse while `stage` is 0 gives no interrupt.
- R6: A `xact_done` pulse in the setup stage moves `stage` to 2 (data) when the latched length is non-zero. When the length is zero, it moves `stage` to 3 (status).
- R7: In the data stage, a token that matches the direction (IN for a read, OUT for a write) keeps `stage` at 2. A token of the opposite direction moves `stage` to 3. Either token is answered per R4.
- R8: In the status stage, the expected token is OUT for a read with a non-zero length and IN for every other case. The expected token is answered per R4. The other token is answered with STALL. `stage` stays 3 in both cases.
- R9: A `xact_done` pulse in the status stage returns `stage` to 0 only when the last handshake sent was ACK. Otherwise `stage` stays 3.
- R10: A SETUP token that arrives during the data or status stage abandons that transfer and restarts it at the setup stage, with the new direction and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_setup | input | 1 | SETUP token pulse for endpoint 0 |
| tok_in | input | 1 | IN token pulse for endpoint 0 |
| tok_out | input | 1 | OUT token pulse for endpoint 0 |
| setup_dir_in | input | 1 | Request direction bit, valid with `tok_setup` (1 = read) |
| setup_len | input | LEN_W | Requested data length, valid with `tok_setup` |
| xact_done | input | 1 | Transaction-complete pulse |
| cpu_rx_en | input | 1 | Firmware: accept OUT data |
| cpu_rx_stall | input | 1 | Firmware: stall OUT |
| cpu_tx_en | input | 1 | Firmware: transmit data ready for IN |
| cpu_tx_stall | input | 1 | Firmware: stall IN |
| hs_valid | output | 1 | Handshake below is valid (one cycle after a token) |
| hs_code | output | 2 | Handshake: 1 ACK, 2 NAK, 3 STALL |
| stage | output | 2 | 0 idle, 1 setup, 2 data, 3 status |
| dir_read | output | 1 | Latched direction of the current request |
| gen_irq | output | 1 | General interrupt pulse at the end of a transaction |

## Verification
The assertions assume that at most one token pulse is high in any cycle. They also assume that `xact_done` never shares a cycle with a token, because the decoder separates the token phase from the end of the transaction. The stimulus respects both assumptions: each step drives exactly one event, either a single token or a completion pulse, and then idles for one cycle while the outputs are sampled. The firmware bits and the setup fields are drawn at random on every step, so the assertions see every combination of enable and stall bits in every stage.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_DATA   = 2'd2,
    ST_STATUS = 2'd3
  } stage_e;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  // Firmware-driven answer: stall outranks a missing enable
  function automatic hs_e hs_pick(input logic en, input logic stall);
    if (stall)    return HS_STALL;
    else if (!en) return HS_NAK;
    else          return HS_ACK;
  endfunction

  // Status transaction runs IN except after a read that moved data
  function automatic logic status_is_in(input logic rd, input logic zero);
    return !(rd && !zero);
  endfunction

endpackage

// File: rtl/ctl_seq_hs.sv
module ctl_seq_hs
  import ctl_seq_pkg::*;
(
  input  stage_e stage,
  input  logic   dir_read,
  input  logic   zero_len,
  input  logic   tok_setup,
  input  logic   tok_in,
  input  logic   tok_out,
  input  logic   cpu_rx_en,
  input  logic   cpu_rx_stall,
  input  logic   cpu_tx_en,
  input  logic   cpu_tx_stall,
  output hs_e    hs_next,
  output logic   to_status
);

  logic fw_en, fw_stall, in_req;
  hs_e  fw_hs;

  assign fw_en    = tok_in ? cpu_tx_en    : cpu_rx_en;
  assign fw_stall = tok_in ? cpu_tx_stall : cpu_rx_stall;
  assign fw_hs    = hs_pick(fw_en, fw_stall);

  always_comb begin
    hs_next   = HS_NONE;
    to_status = 1'b0;
    if (tok_setup) begin
      hs_next = HS_ACK;
    end else if (tok_in || tok_out) begin
      unique case (stage)
        ST_IDLE, ST_SETUP: hs_next = HS_STALL;
        ST_DATA: begin
          hs_next   = fw_hs;
          to_status = (tok_in != dir_read);
        end
        ST_STATUS: begin
          hs_next = (tok_in == status_is_in(dir_read, zero_len)) ? fw_hs : HS_STALL;
        end
        default: hs_next = HS_STALL;
      endcase
    end
  end

  assign in_req = tok_in;

  always_comb begin
    if (!tok_setup && (tok_in || tok_out) && stage == ST_DATA && in_req && cpu_tx_stall)
      assert (hs_next == HS_STALL) else $error("AST_STALL_WINS"); // R4
  end

endmodule

// File: rtl/ctl_seq_track.sv
module ctl_seq_track
  import ctl_seq_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_setup,
  input  logic             tok_any,
  input  logic             to_status,
  input  logic             xact_done,
  input  logic             setup_dir_in,
  input  logic [LEN_W-1:0] setup_len,
  input  hs_e              hs_next,
  output stage_e           stage,
  output logic             dir_read,
  output logic             zero_len,
  output logic             last_ack
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage    <= ST_IDLE;
      dir_read <= 1'b0;
      zero_len <= 1'b0;
      last_ack <= 1'b0;
    end else if (tok_setup) begin
      stage    <= ST_SETUP;
      dir_read <= setup_dir_in;
      zero_len <= (setup_len == '0);
      last_ack <= 1'b1;
    end else if (tok_any) begin
      last_ack <= (hs_next == HS_ACK);
      if (to_status) stage <= ST_STATUS;
    end else if (xact_done) begin
      unique case (stage)
        ST_SETUP:  stage <= zero_len ? ST_STATUS : ST_DATA;
        ST_STATUS: if (last_ack) stage <= ST_IDLE;
        default:   stage <= stage;
      endcase
    end
  end

  AST_SETUP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    tok_setup |=> stage == ST_SETUP); // R10

  AST_SETUP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (xact_done && !tok_setup && !tok_any && stage == ST_SETUP) |=> (stage == ST_DATA || stage == ST_STATUS)); // R6

  AST_STATUS_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (xact_done && !tok_setup && !tok_any && stage == ST_STATUS && last_ack) |=> stage == ST_IDLE); // R9

endmodule

// File: rtl/ctl_ep_seq.sv
module ctl_ep_seq
  import ctl_seq_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_setup,
  input  logic             tok_in,
  input  logic             tok_out,
  input  logic             setup_dir_in,
  input  logic [LEN_W-1:0] setup_len,
  input  logic             xact_done,
  input  logic             cpu_rx_en,
  input  logic             cpu_rx_stall,
  input  logic             cpu_tx_en,
  input  logic             cpu_tx_stall,
  output logic             hs_valid,
  output logic [1:0]       hs_code,
  output logic [1:0]       stage,
  output logic             dir_read,
  output logic             gen_irq
);

  stage_e stage_q;
  hs_e    hs_next;
  logic   to_status, zero_len, last_ack, tok_any, ctl_active;

  assign tok_any    = tok_in || tok_out;
  assign ctl_active = (stage_q != ST_IDLE);

  ctl_seq_hs u_hs (
    .stage        (stage_q),
    .dir_read     (dir_read),
    .zero_len     (zero_len),
    .tok_setup    (tok_setup),
    .tok_in       (tok_in),
    .tok_out      (tok_out),
    .cpu_rx_en    (cpu_rx_en),
    .cpu_rx_stall (cpu_rx_stall),
    .cpu_tx_en    (cpu_tx_en),
    .cpu_tx_stall (cpu_tx_stall),
    .hs_next      (hs_next),
    .to_status    (to_status)
  );

  ctl_seq_track #(.LEN_W(LEN_W)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .tok_setup    (tok_setup),
    .tok_any      (tok_any),
    .to_status    (to_status),
    .xact_done    (xact_done),
    .setup_dir_in (setup_dir_in),
    .setup_len    (setup_len),
    .hs_next      (hs_next),
    .stage        (stage_q),
    .dir_read     (dir_read),
    .zero_len     (zero_len),
    .last_ack     (last_ack)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_valid <= 1'b0;
      hs_code  <= HS_NONE;
      gen_irq  <= 1'b0;
    end else begin
      hs_valid <= tok_setup || tok_any;
      hs_code  <= hs_next;
      gen_irq  <= xact_done && ctl_active;
    end
  end

  assign stage = stage_q;

  AST_ONE_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tok_setup, tok_in, tok_out})); // R2

  AST_SETUP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    tok_setup |=> (hs_valid && hs_code == HS_ACK)); // R2

  AST_IDLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_any && !tok_setup && !ctl_active) |=> (hs_valid && hs_code == HS_STALL)); // R3

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (xact_done && ctl_active) |=> gen_irq); // R5

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    gen_irq |=> (!gen_irq || $past(xact_done))); // R5

endmodule

// File: tb/ctl_ep_seq_tb_top.sv
module ctl_ep_seq_tb_top;

  localparam int LEN_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tok_setup = 0, tok_in = 0, tok_out = 0;
  logic             setup_dir_in = 0;
  logic [LEN_W-1:0] setup_len = '0;
  logic             xact_done = 0;
  logic             cpu_rx_en = 0, cpu_rx_stall = 0, cpu_tx_en = 0, cpu_tx_stall = 0;
  logic             hs_valid, dir_read, gen_irq;
  logic [1:0]       hs_code, stage;

  int vectors = 0;
  int errors  = 0;

  // bench model state
  int m_stage = 0;
  bit m_dir = 0, m_zero = 0, m_ack = 0;

  always #2.5 clk = ~clk;

  ctl_ep_seq #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tok_setup(tok_setup), .tok_in(tok_in), .tok_out(tok_out),
    .setup_dir_in(setup_dir_in), .setup_len(setup_len), .xact_done(xact_done),
    .cpu_rx_en(cpu_rx_en), .cpu_rx_stall(cpu_rx_stall), .cpu_tx_en(cpu_tx_en),
    .cpu_tx_stall(cpu_tx_stall), .hs_valid(hs_valid), .hs_code(hs_code), .stage(stage),
    .dir_read(dir_read), .gen_irq(gen_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // 1 ACK, 2 NAK, 3 STALL
  function automatic int fw_answer(input bit en, input bit st);
    if (st) return 3;
    return en ? 1 : 2;
  endfunction

  // kind: 0 setup, 1 IN, 2 OUT, 3 done
  task automatic step(input int kind, input bit dir, input logic [LEN_W-1:0] len,
                      input bit rxe, input bit rxs, input bit txe, input bit txs);
    int  e_hs;
    int  e_irq;
    bit  is_in;
    @(negedge clk);
    cpu_rx_en = rxe; cpu_rx_stall = rxs; cpu_tx_en = txe; cpu_tx_stall = txs;
    setup_dir_in = dir; setup_len = len;
    tok_setup = (kind == 0); tok_in = (kind == 1); tok_out = (kind == 2);
    xact_done = (kind == 3);
    e_hs = 0; e_irq = 0;
    is_in = (kind == 1);
    if (kind == 0) begin
      e_hs = 1; m_stage = 1; m_dir = dir; m_zero = (len == 0); m_ack = 1;
    end else if (kind == 1 || kind == 2) begin
      int fw;
      fw = is_in ? fw_answer(txe, txs) : fw_answer(rxe, rxs);
      if (m_stage < 2) e_hs = 3;
      else if (m_stage == 2) begin
        e_hs = fw;
        if (is_in != m_dir) m_stage = 3;
      end else begin
        bit want_in;
        want_in = !(m_dir && !m_zero);
        e_hs = (is_in == want_in) ? fw : 3;
      end
      m_ack = (e_hs == 1);
    end else begin
      e_irq = (m_stage != 0);
      if (m_stage == 1) m_stage = m_zero ? 3 : 2;
      else if (m_stage == 3 && m_ack) m_stage = 0;
    end
    @(negedge clk);
    tok_setup = 0; tok_in = 0; tok_out = 0; xact_done = 0;
    if (kind == 0) begin
      check("R2 setup ack", hs_code, 1);
      check("R2 dir latch", dir_read, dir);
    end else if (kind < 3) begin
      if (e_hs == 3 && m_stage < 2) check("R3 stall outside request", hs_code, e_hs);
      else if (m_stage == 3) check("R8 status handshake", hs_code, e_hs);
      else check("R4 data handshake", hs_code, e_hs);
    end else begin
      check("R5 irq", gen_irq, e_irq);
    end
    check((kind == 3) ? "R5 no handshake on done" : "R2 hs_valid", hs_valid, (kind < 3));
    check((kind == 3) ? "R9 stage after done" : "R7 stage after token", stage, m_stage);
    @(negedge clk);
    check("R5 irq one cycle", gen_irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset stage", stage, 0);
    check("R1 reset hs_valid", hs_valid, 0);
    check("R1 reset irq", gen_irq, 0);
    rst_n = 1;
    // directed: done while idle gives no irq (R5), IN while idle stalls (R3)
    step(3, 0, 0, 1, 0, 1, 0);
    step(1, 0, 0, 1, 0, 1, 0);
    // control read with data (R6, R7, R8, R9)
    step(0, 1, 16'd64, 0, 0, 0, 0);
    step(1, 0, 0, 1, 0, 1, 0);          // R3 IN during setup stage
    step(3, 0, 0, 0, 0, 0, 0);          // R6 -> data
    step(1, 0, 0, 0, 0, 0, 0);          // R4 NAK
    step(1, 0, 0, 0, 0, 1, 1);          // R4 stall wins
    step(1, 0, 0, 0, 0, 1, 0);          // R4 ACK
    step(3, 0, 0, 0, 0, 0, 0);
    step(2, 0, 0, 1, 0, 0, 0);          // R7 -> status
    step(1, 0, 0, 1, 0, 1, 0);          // R8 wrong token stall
    step(3, 0, 0, 0, 0, 0, 0);          // R9 stays status
    step(2, 0, 0, 1, 0, 0, 0);
    step(3, 0, 0, 0, 0, 0, 0);          // R9 -> idle
    // zero-length write, restart mid-transfer (R10)
    step(0, 0, 16'd0, 0, 0, 0, 0);
    step(3, 0, 0, 0, 0, 0, 0);          // R6 -> status
    step(0, 0, 16'd8, 0, 0, 0, 0);      // R10 restart
    step(3, 0, 0, 0, 0, 0, 0);
    step(2, 0, 0, 1, 0, 0, 0);
    step(0, 1, 16'd2, 0, 0, 0, 0);      // R10 restart from data
    // constrained random
    void'($urandom(32'h5eed_0123));
    for (int i = 0; i < 3000; i++) begin
      int r, k;
      r = $urandom_range(99);
      k = (r < 12) ? 0 : (r < 42) ? 1 : (r < 72) ? 2 : 3;
      step(k, 1'($urandom), ($urandom_range(3) == 0) ? '0 : LEN_W'($urandom),
           1'($urandom), ($urandom_range(4) == 0), 1'($urandom), ($urandom_range(4) == 0));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule